// File: doc/BRIEF.md
# Multiply-Accumulate Coprocessor

This block is an unsigned 32x32 multiplier with a 64-bit accumulator. It sits next to a small processor core and is reached through a window of three transfer registers, indexed 25, 26 and 27 in the core's transfer space. Register 25 holds the mode bit and the carry flag. Registers 26 and 27 hold the low and high words of the 64-bit result. Both operands arrive on two dedicated 32-bit inputs that mirror two core registers.

The block has two modes. In multiply-only mode (mode bit 0), every core step (`step_i` high) loads the product of the operands into the result words and clears the accumulator. In accumulate mode (mode bit 1), nothing happens on a step. Instead, every write that touches register 25 samples the operands and adds their product into the accumulator. The new sum is also placed in the result words. A 64-bit wrap of that addition raises a sticky carry flag. Software clears the flag by writing a 1 to it, and the same write empties the accumulator.

A transfer names a start register, a start byte and a length in bytes. The window is one 96-bit bus of twelve byte lanes. Lane k covers bits [8k+7:8k] and maps to byte k mod 4 of register 25 + k/4.

Top module: `mac_coproc`

## Requirements
- R1: While reset is asserted and after it is released, the mode bit, the carry flag, the accumulator and both result words are zero. A read of the whole window therefore returns zero, and the block starts in multiply-only mode.
- R2: The window layout is as follows. Register 25 bit 0 (lane 0, bit 0) is the mode bit. Register 25 bit 1 is the carry flag. All other bits of register 25 read as zero. Register 26 is result bits 31:0 (lanes 4 to 7). Register 27 is result bits 63:32 (lanes 8 to 11). A transfer with start register r, start byte b and length n covers lanes (r-25)*4+b up to (r-25)*4+b+n-1.
- R3: A transfer is rejected if any of these holds: its start register is below 25, its length is 0, or it runs past lane 11. On the following cycle a rejected transfer raises `xfr_err_o` for one cycle and returns zero read data. It changes no state.
- R4: A legal read returns, on the following cycle, the window contents from before that clock edge in the covered lanes, and zero in all other lanes. A write, an idle cycle or a rejected transfer returns all-zero read data. `xfr_err_o` is low for every legal transfer and on idle cycles.
- R5: The mode bit in force for a cycle is the one left by any write in that cycle. When `step_i` is high and that mode bit is 0, the result words take the full 64-bit unsigned product of the operands, and the accumulator is cleared.
- R6: When a legal write covers any lane of register 25 and leaves the mode bit at 1, the accumulator becomes the old accumulator plus the 64-bit product of the operands, and the result words take the same sum. In accumulate mode `step_i` has no effect.
- R7: The carry flag is set when an accumulation wraps, that is, when the new sum is below the value it was added to. The flag then stays set until it is cleared. Writing a 0 to it has no effect.
- R8: A legal write that covers lane 0 with bit 1 set clears the carry flag and zeroes the accumulator before the accumulation of that same write. The sum is then just the product.
- R9: A legal write to lanes of registers 26 and 27 replaces only the covered bytes of the result words. Those bytes persist while the block is in accumulate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | One core step; drives multiplication in multiply-only mode |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| xfr_valid_i | input | 1 | Transfer request this cycle |
| xfr_write_i | input | 1 | 1 = write into the window, 0 = read |
| xfr_reg_i | input | 5 | Start register index |
| xfr_byte_i | input | 2 | Start byte within the start register |
| xfr_len_i | input | 4 | Length in bytes |
| xfr_wdata_i | input | 96 | Write data, one byte per window lane |
| xfr_rdata_o | output | 96 | Read data, one cycle after the request, uncovered lanes zero |
| xfr_err_o | output | 1 | Rejected transfer, one cycle after the request |

## Verification
The bench aims its directed cases at the points where the two modes meet the write path.

- **Mode changes.** A write that sets the mode bit is followed by steps. A design that ignored the mode bit would overwrite the sum with a plain product.
- **Two-product wrap.** Two maximal products are summed so that the addition wraps. A carry compare made on the wrong operand would leave the flag clear.
- **Clearing the flag.** A write of the clear bit during accumulation checks two things. Clearing after the add would return zero instead of the product. Writing a 0 to the flag must leave it set.
- **Boundaries.** Transfers starting at register 24, running one byte past lane 11, or of length 0 or 13 must be refused. An off-by-one limit would corrupt state or flag the wrong transfer.
- **Partial writes.** Byte-partial writes to the result words expose lane-mask shifts.

A long random run then mixes every transfer shape with step patterns and operands near all-ones.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned WORD_BYTES  = WORD_W / 8;
  localparam int unsigned WIN_WORDS   = 3;
  localparam int unsigned WIN_LANES   = WIN_WORDS * WORD_BYTES;
  localparam int unsigned WIN_W       = WIN_LANES * 8;
  localparam int unsigned IDX_W       = 5;
  localparam int unsigned BSEL_W      = $clog2(WORD_BYTES);
  localparam int unsigned LEN_W       = 4;
  localparam int unsigned MODE_POS    = 0;
  localparam int unsigned CARRY_POS   = 1;
  typedef logic [2*WORD_W-1:0] dword_t;
endpackage

// File: rtl/mac_xfr_decode.sv
module mac_xfr_decode
  import mac_pkg::*;
#(
  parameter int unsigned BASE = 25
) (
  input  logic [IDX_W-1:0]     reg_i,
  input  logic [BSEL_W-1:0]    byte_i,
  input  logic [LEN_W-1:0]     len_i,
  output logic                 ok_o,
  output logic [WIN_LANES-1:0] lane_o
);
  localparam int unsigned OFF_W = IDX_W + BSEL_W + 2;

  logic [OFF_W-1:0] first_lane;
  logic [OFF_W-1:0] end_lane;

  always_comb begin
    first_lane = OFF_W'({reg_i, byte_i}) - OFF_W'(BASE * WORD_BYTES);
    end_lane   = first_lane + OFF_W'(len_i);
    ok_o       = (reg_i >= IDX_W'(BASE)) && (len_i != '0)
                 && (end_lane <= OFF_W'(WIN_LANES));
  end

  for (genvar k = 0; k < WIN_LANES; k++) begin : g_lane
    assign lane_o[k] = ok_o && (first_lane <= OFF_W'(k)) && (OFF_W'(k) < end_lane);
  end
endmodule

// File: rtl/mac_lane_merge.sv
module mac_lane_merge
  import mac_pkg::*;
(
  input  logic [WIN_W-1:0]     cur_i,
  input  logic [WIN_W-1:0]     wdata_i,
  input  logic [WIN_LANES-1:0] lane_i,
  output logic [WIN_W-1:0]     merged_o,
  output logic [WIN_W-1:0]     bmask_o
);
  for (genvar k = 0; k < WIN_LANES; k++) begin : g_lane
    assign merged_o[8*k +: 8] = lane_i[k] ? wdata_i[8*k +: 8] : cur_i[8*k +: 8];
    assign bmask_o[8*k +: 8]  = {8{lane_i[k]}};
  end
endmodule

// File: rtl/mac_arith.sv
module mac_arith
  import mac_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  dword_t            acc_i,
  output dword_t            prod_o,
  output dword_t            sum_o,
  output logic              wrap_o
);
  always_comb begin
    prod_o = {{WORD_W{1'b0}}, a_i} * {{WORD_W{1'b0}}, b_i};
    sum_o  = acc_i + prod_o;
    wrap_o = (sum_o < acc_i);
  end
endmodule

// File: rtl/mac_coproc.sv
module mac_coproc
  import mac_pkg::*;
#(
  parameter int unsigned WIN_BASE = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_i,
  input  logic [WORD_W-1:0]    opa_i,
  input  logic [WORD_W-1:0]    opb_i,
  input  logic                 xfr_valid_i,
  input  logic                 xfr_write_i,
  input  logic [IDX_W-1:0]     xfr_reg_i,
  input  logic [BSEL_W-1:0]    xfr_byte_i,
  input  logic [LEN_W-1:0]     xfr_len_i,
  input  logic [WIN_W-1:0]     xfr_wdata_i,
  output logic [WIN_W-1:0]     xfr_rdata_o,
  output logic                 xfr_err_o
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // Architectural state.
  logic   mode_q, carry_q;
  dword_t acc_q, prod_q;
  logic   mode_n, carry_n;
  dword_t acc_n, prod_n;
  logic   upd_en;
  logic [WIN_W-1:0] rdata_q, rdata_n;
  logic   err_q, err_n;

  // Transfer decode and lane merge.
  logic                 xfr_ok;
  logic [WIN_LANES-1:0] lanes;
  logic [WIN_W-1:0]     win_img, win_merged, win_bmask;

  assign win_img = {prod_q, {(WORD_W-2){1'b0}}, carry_q, mode_q};

  mac_xfr_decode #(.BASE(WIN_BASE)) u_decode (
    .reg_i  (xfr_reg_i),
    .byte_i (xfr_byte_i),
    .len_i  (xfr_len_i),
    .ok_o   (xfr_ok),
    .lane_o (lanes)
  );

  mac_lane_merge u_merge (
    .cur_i    (win_img),
    .wdata_i  (xfr_wdata_i),
    .lane_i   (lanes),
    .merged_o (win_merged),
    .bmask_o  (win_bmask)
  );

  // Arithmetic on the accumulator after any clear of this cycle.
  logic   wr_ok, rd_ok, mode_wr, w1c;
  logic   carry_base;
  dword_t acc_base, prod_val, sum_val;
  logic   wrap;

  mac_arith u_arith (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .acc_i  (acc_base),
    .prod_o (prod_val),
    .sum_o  (sum_val),
    .wrap_o (wrap)
  );

  // Next-state logic.
  always_comb begin
    wr_ok      = xfr_valid_i && xfr_write_i && xfr_ok;
    rd_ok      = xfr_valid_i && !xfr_write_i && xfr_ok;
    mode_wr    = wr_ok && (|lanes[WORD_BYTES-1:0]);
    w1c        = wr_ok && lanes[0] && xfr_wdata_i[CARRY_POS];
    mode_n     = wr_ok ? win_merged[MODE_POS] : mode_q;
    acc_base   = w1c ? '0 : acc_q;
    carry_base = w1c ? 1'b0 : carry_q;
    prod_n     = wr_ok ? win_merged[WIN_W-1:WORD_W] : prod_q;
    acc_n      = acc_base;
    carry_n    = carry_base;
    if (mode_wr && mode_n) begin
      acc_n   = sum_val;
      prod_n  = sum_val;
      carry_n = carry_base | wrap;
    end else if (step_i && !mode_n) begin
      prod_n  = prod_val;
      acc_n   = '0;
    end
    upd_en  = wr_ok || (step_i && !mode_n);
    rdata_n = rd_ok ? (win_img & win_bmask) : '0;
    err_n   = xfr_valid_i && !xfr_ok;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mode_q  <= 1'b0;
      carry_q <= 1'b0;
      acc_q   <= '0;
      prod_q  <= '0;
    end else if (upd_en) begin
      mode_q  <= mode_n;
      carry_q <= carry_n;
      acc_q   <= acc_n;
      prod_q  <= prod_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_n;
      err_q   <= err_n;
    end
  end

  assign xfr_rdata_o = rdata_q;
  assign xfr_err_o   = err_q;
endmodule

// File: rtl/mac_coproc_chk.sv
module mac_coproc_chk
  import mac_pkg::*;
(
  input logic              clk,
  input logic              rst_n_int,
  input logic              step_i,
  input logic [WORD_W-1:0] opa_i,
  input logic [WORD_W-1:0] opb_i,
  input logic              xfr_valid_i,
  input logic              xfr_write_i,
  input logic [WIN_W-1:0]  xfr_rdata_o,
  input logic              xfr_err_o,
  input logic              mode_q,
  input logic              carry_q,
  input dword_t            acc_q,
  input dword_t            prod_q
);
  AST_REJECT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n_int)
    xfr_err_o |-> (xfr_rdata_o == '0)); // R3

  AST_REJECT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n_int)
    xfr_err_o |-> (mode_q == $past(mode_q) && carry_q == $past(carry_q))); // R3

  AST_WRITE_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n_int)
    (xfr_valid_i && xfr_write_i) |=> (xfr_rdata_o == '0)); // R4

  AST_MULT_EVERY_STEP: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_i && !xfr_valid_i && !mode_q) |=>
      (prod_q == ({{WORD_W{1'b0}}, $past(opa_i)} * {{WORD_W{1'b0}}, $past(opb_i)})
       && acc_q == '0)); // R5

  AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode_q && !xfr_valid_i) |=> ($stable(acc_q) && $stable(prod_q))); // R6

  AST_CARRY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(carry_q) |-> $past(xfr_valid_i && xfr_write_i)); // R7
endmodule

bind mac_coproc mac_coproc_chk u_chk (
  .clk         (clk),
  .rst_n_int   (rst_n_int),
  .step_i      (step_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .xfr_valid_i (xfr_valid_i),
  .xfr_write_i (xfr_write_i),
  .xfr_rdata_o (xfr_rdata_o),
  .xfr_err_o   (xfr_err_o),
  .mode_q      (mode_q),
  .carry_q     (carry_q),
  .acc_q       (acc_q),
  .prod_q      (prod_q)
);

// File: tb/mac_coproc_tb_top.sv
module mac_coproc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_i;
  logic [31:0] opa_i, opb_i;
  logic        xfr_valid_i, xfr_write_i;
  logic [4:0]  xfr_reg_i;
  logic [1:0]  xfr_byte_i;
  logic [3:0]  xfr_len_i;
  logic [95:0] xfr_wdata_i;
  logic [95:0] xfr_rdata_o;
  logic        xfr_err_o;

  always #10 clk = ~clk;

  mac_coproc dut_i (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .opa_i(opa_i), .opb_i(opb_i),
    .xfr_valid_i(xfr_valid_i), .xfr_write_i(xfr_write_i), .xfr_reg_i(xfr_reg_i),
    .xfr_byte_i(xfr_byte_i), .xfr_len_i(xfr_len_i), .xfr_wdata_i(xfr_wdata_i),
    .xfr_rdata_o(xfr_rdata_o), .xfr_err_o(xfr_err_o)
  );

  int checks = 0;
  int errors = 0;

  // Reference state, built from the requirements.
  logic        m_mode, m_carry;
  logic [63:0] m_acc, m_res;

  function automatic logic [95:0] m_window();
    return {m_res, 30'b0, m_carry, m_mode};
  endfunction

  function automatic bit legal(int r, int b, int n);
    int first = (r - 25) * 4 + b;
    return (r >= 25) && (n >= 1) && (first + n <= 12);
  endfunction

  function automatic logic [95:0] lane_mask(int r, int b, int n);
    logic [95:0] m = '0;
    int first = (r - 25) * 4 + b;
    for (int k = 0; k < 12; k++)
      if (k >= first && k < first + n) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic check(string tag, logic [95:0] got, logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, advance the reference, compare after the next edge.
  task automatic cyc(string tag, bit v, bit w, int r, int b, int n,
                     logic [95:0] wd, bit st, logic [31:0] a, logic [31:0] bb);
    logic [95:0] exp_rd, msk, img, nimg;
    logic        exp_err, ok, mwr, clr;
    logic [63:0] pr, sum;
    xfr_valid_i = v; xfr_write_i = w; xfr_reg_i = 5'(r); xfr_byte_i = 2'(b);
    xfr_len_i = 4'(n); xfr_wdata_i = wd; step_i = st; opa_i = a; opb_i = bb;
    ok      = v && legal(r, b, n);
    msk     = ok ? lane_mask(r, b, n) : '0;
    img     = m_window();
    exp_rd  = (ok && !w) ? (img & msk) : '0;
    exp_err = v && !ok;
    pr      = {32'b0, a} * {32'b0, bb};
    if (ok && w) begin
      nimg   = (img & ~msk) | (wd & msk);
      m_mode = nimg[0];
      m_res  = nimg[95:32];
      mwr    = |msk[31:0];
      clr    = msk[0] && wd[1];
      if (clr) begin m_carry = 1'b0; m_acc = '0; end
      if (mwr && m_mode) begin
        sum = m_acc + pr;
        if (sum < m_acc) m_carry = 1'b1;
        m_acc = sum; m_res = sum;
      end else if (st && !m_mode) begin
        m_res = pr; m_acc = '0;
      end
    end else if (st && !m_mode) begin
      m_res = pr; m_acc = '0;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " rdata"}, xfr_rdata_o, exp_rd);
    check({tag, " err"}, {95'b0, xfr_err_o}, {95'b0, exp_err});
  endtask

  task automatic rd(string tag, int r, int b, int n, bit st, logic [31:0] a, logic [31:0] bb);
    cyc(tag, 1'b1, 1'b0, r, b, n, '0, st, a, bb);
  endtask

  task automatic wr(string tag, int r, int b, int n, logic [95:0] wd,
                    bit st, logic [31:0] a, logic [31:0] bb);
    cyc(tag, 1'b1, 1'b1, r, b, n, wd, st, a, bb);
  endtask

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_mode = 0; m_carry = 0; m_acc = '0; m_res = '0;
    rst_n = 1'b0; step_i = 0; opa_i = '0; opb_i = '0; xfr_valid_i = 0;
    xfr_write_i = 0; xfr_reg_i = '0; xfr_byte_i = '0; xfr_len_i = '0; xfr_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state.
    check("R1 idle rdata", xfr_rdata_o, '0);
    check("R1 idle err", {95'b0, xfr_err_o}, '0);
    rd("R1 full window", 25, 0, 12, 0, 0, 0);

    // R5: multiply-only, product every step.
    cyc("R5 step", 0, 0, 0, 0, 0, '0, 1, 32'h12345678, 32'h9ABCDEF0);
    rd("R5 read product", 26, 0, 8, 1, 32'hFFFFFFFF, 32'h00000002);
    rd("R5 second product", 26, 0, 8, 0, 0, 0);
    cyc("R5 no step holds", 0, 0, 0, 0, 0, '0, 0, 32'h7, 32'h7);
    rd("R5 hold read", 26, 0, 8, 0, 0, 0);

    // R6: accumulate on mode writes, steps ignored.
    wr("R6 enter acc", 25, 0, 1, 96'h1, 1, 32'd3, 32'd5);
    wr("R6 second add", 25, 0, 1, 96'h1, 0, 32'd7, 32'd2);
    cyc("R6 step ignored", 0, 0, 0, 0, 0, '0, 1, 32'hDEAD, 32'hBEEF);
    rd("R6 read sum", 25, 0, 12, 1, 32'h1, 32'h1);
    wr("R6 upper byte write", 25, 2, 1, 96'h0, 0, 32'd4, 32'd4);
    rd("R6 read after byte2", 26, 0, 8, 0, 0, 0);

    // R8: write-1-to-clear before the add; R7: wrap sets sticky carry.
    wr("R8 clear start", 25, 0, 1, 96'h3, 0, 0, 0);
    wr("R7 big add 1", 25, 0, 1, 96'h1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    wr("R7 big add 2", 25, 0, 1, 96'h1, 0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    rd("R7 carry set", 25, 0, 1, 0, 0, 0);
    wr("R7 write zero keeps", 25, 0, 1, 96'h1, 0, 32'd1, 32'd1);
    rd("R7 carry sticky", 25, 0, 12, 0, 0, 0);
    wr("R8 clear and add", 25, 0, 1, 96'h3, 0, 32'd9, 32'd11);
    rd("R8 result is product", 25, 0, 12, 0, 0, 0);

    // R9: partial writes to the result words.
    wr("R9 lanes 5-6", 26, 1, 2, 96'h0000_0000_00AB_CD00_0000_0000, 1, 32'h5, 32'h5);
    rd("R9 read back", 26, 0, 8, 1, 0, 0);
    wr("R9 lane 11", 27, 3, 1, {8'h5A, 88'h0}, 0, 0, 0);
    rd("R9 read high", 27, 0, 4, 0, 0, 0);

    // R3: rejected transfers.
    wr("R3 below window", 24, 0, 4, 96'h0, 0, 32'h3, 32'h3);
    wr("R3 past end", 27, 3, 2, '1, 0, 32'h3, 32'h3);
    wr("R3 zero length", 25, 0, 0, 96'h3, 0, 32'h3, 32'h3);
    rd("R3 too long", 25, 0, 13, 0, 0, 0);
    rd("R3 above window", 28, 0, 1, 0, 0, 0);
    rd("R3 state kept", 25, 0, 12, 0, 0, 0);
    rd("R4 edge legal", 27, 3, 1, 0, 0, 0);
    rd("R2 mid-register", 25, 3, 6, 0, 0, 0);

    // R5: back to multiply-only via mode write with step in the same cycle.
    wr("R5 leave acc", 25, 0, 1, 96'h0, 1, 32'hCAFEF00D, 32'h10203040);
    rd("R5 product after exit", 25, 0, 12, 0, 0, 0);

    // Random mix.
    for (int i = 0; i < 6000; i++) begin
      int r = 23 + int'($urandom % 6);
      int b = int'($urandom % 4);
      int n = int'($urandom % 14);
      bit v = ($urandom % 4) != 0;
      bit w = ($urandom % 2) == 1;
      bit st = ($urandom % 3) != 0;
      logic [31:0] a  = ($urandom % 4 == 0) ? 32'hFFFFFFFF : $urandom;
      logic [31:0] bb = ($urandom % 4 == 0) ? 32'hFFFFFFFE : $urandom;
      logic [95:0] wd = {$urandom, $urandom, $urandom};
      if ($urandom % 2 == 0) wd[0] = 1'b1;
      if ($urandom % 4 != 0) wd[1] = 1'b0;
      cyc("R4 random", v, w, r, b, n, wd, st, a, bb);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule